// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it stays quiet for a fixed pause. It then runs a burst of eight refresh cycles and raises `init_done`. From then on, a free-running interval timer adds one owed refresh for each period that covers a share of the retention window. Every refresh is of the CAS-before-RAS kind. Both column strobes drop before the row strobe, so the device's own row counter picks the row and no address is driven.

The block shares the memory pins with an access controller through a request/grant pair. `ref_req` stays high for as long as at least one refresh is owed. While `ref_gnt` is high the block drives the row strobe, both column strobes and the write strobe directly, and the controller routes those pins to the device. The owed count saturates at eight, so a controller that holds off for a long time still gets all the refreshes the device needs once it grants.

The sequencer is a single state machine with these states: SEQ_PAUSE, SEQ_WAIT_GNT, SEQ_CAS_LEAD, SEQ_RAS_ACTIVE and SEQ_PRECHARGE. Its transitions are:
- pause-expired: SEQ_PAUSE to SEQ_WAIT_GNT. This loads the initial burst of eight.
- grant-taken: SEQ_WAIT_GNT to SEQ_CAS_LEAD. It happens when a refresh is owed and `ref_gnt` is high.
- lead-done: SEQ_CAS_LEAD to SEQ_RAS_ACTIVE.
- ras-done: SEQ_RAS_ACTIVE to SEQ_PRECHARGE.
- cycle-done: SEQ_PRECHARGE to SEQ_WAIT_GNT. This retires one owed refresh.

Time values given in ns and µs become clock-cycle counts through the clock-frequency parameter.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n`, `ucas_n`, `lcas_n` and `we_n` are 1 (strobes are active low), and `ref_req` and `init_done` are 0.
- R2: `ref_req` stays 0 and all strobes stay high for the first PAUSE_US×CLK_MHZ cycles after reset. `ref_req` becomes 1 in the cycle after that count expires.
- R3: Exactly eight refresh cycles (row-strobe falls) occur before `init_done` rises. `init_done` then stays 1 until the next reset.
- R4: In every refresh, both column strobes are low for exactly CAS_SETUP_CYC cycles before the row strobe falls. They stay low for exactly CAS_HOLD_CYC cycles after it falls, and they rise while the row strobe is still low. `ucas_n` always equals `lcas_n`.
- R5: The row strobe stays low for exactly ceil(T_RAS_NS×CLK_MHZ/1000) cycles per refresh.
- R6: Between refreshes the row strobe stays high for at least ceil(T_RP_NS×CLK_MHZ/1000) cycles. Successive row-strobe falls are at least ceil(T_RC_NS×CLK_MHZ/1000) cycles apart.
- R7: `we_n` is 1 at all times.
- R8: A strobe is low only while `ref_gnt` is 1. With the grant withheld, `ref_req` stays high and no strobe moves.
- R9: After `init_done` rises, one refresh becomes owed every RETENTION_US×CLK_MHZ/ROWS cycles. The first `ref_req` rise comes exactly one period after `init_done` rises. With prompt grants, exactly one refresh runs per period.
- R10: Owed refreshes accumulate while the grant is withheld, up to a ceiling of eight. After a late grant, the block runs min(owed, 8) refreshes back to back before it drops `ref_req`.
- R11: `ref_req` falls only in the cycle after a refresh's precharge phase ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Grant from the access controller; the pins belong to this block while it is high |
| ref_req | output | 1 | Request for the pins; high while any refresh is owed |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | High once the pause and the initial burst are complete |

## Verification
The embedded assertions check properties that hold on every cycle:
- the row strobe falls only after both column strobes are already low;
- the row-strobe low time is exact;
- strobes move only under grant;
- the owed count stays bounded and is never decremented at zero;
- the request drops only right after a precharge;
- no interval tick arrives before `init_done`, and `init_done` is sticky.

The bench's scenarios show the rest:
- the exact pause length and the eight-refresh initial burst;
- the spacing of periodic requests after `init_done`;
- the number of refreshes replayed after grants are withheld for three periods and for twelve periods (saturation);
- the precharge and cycle-time minimums under random grant latency.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        SEQ_PAUSE,
        SEQ_WAIT_GNT,
        SEQ_CAS_LEAD,
        SEQ_RAS_ACTIVE,
        SEQ_PRECHARGE
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int PERIOD_CYC = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick = en && (cnt_q == LAST);
    end

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
    parameter int MAX_OWED  = 8,
    parameter int INIT_LOAD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_init,
    input  logic inc,
    input  logic dec,
    output logic any_owed
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);
    localparam logic [OW-1:0] BURST = OW'(INIT_LOAD);

    logic [OW-1:0] owed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (load_init) begin
            owed_q <= BURST;
        end else if (inc && !dec) begin
            if (owed_q != CEIL) begin
                owed_q <= owed_q + 1'b1;
            end
        end else if (dec && !inc) begin
            if (owed_q != '0) begin
                owed_q <= owed_q - 1'b1;
            end
        end
    end

    always_comb begin
        any_owed = (owed_q != '0);
    end

    assert_owed_bounded_R10 : assert property (
        @(posedge clk) disable iff (!rst_n) owed_q <= CEIL
    );

    assert_no_retire_at_zero_R10 : assert property (
        @(posedge clk) disable iff (!rst_n) dec |-> (owed_q != '0)
    );

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYC     = 40000,
    parameter int CAS_SETUP_CYC = 1,
    parameter int CAS_HOLD_CYC  = 2,
    parameter int RAS_LOW_CYC   = 12,
    parameter int PRE_CYC       = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic any_owed,
    output logic load_init,
    output logic retire,
    output logic req,
    output logic ras_n,
    output logic ucas_n,
    output logic lcas_n,
    output logic we_n,
    output logic ready
);
    localparam int MAXD = max2(max2(PAUSE_CYC, CAS_SETUP_CYC), max2(RAS_LOW_CYC, PRE_CYC));
    localparam int DW = $clog2(MAXD + 1);
    localparam logic [DW-1:0] PAUSE_LD = DW'(PAUSE_CYC - 1);
    localparam logic [DW-1:0] SETUP_LD = DW'(CAS_SETUP_CYC - 1);
    localparam logic [DW-1:0] RAS_LD   = DW'(RAS_LOW_CYC - 1);
    localparam logic [DW-1:0] PRE_LD   = DW'(PRE_CYC - 1);
    localparam logic [DW-1:0] HOLD_TH  = DW'(RAS_LOW_CYC - CAS_HOLD_CYC);

    seq_state_e    state_q, state_d;
    logic [DW-1:0] dwell_q, dwell_d;
    logic          ready_q;
    logic          cas_low;

    // next-state logic
    always_comb begin
        state_d = state_q;
        dwell_d = dwell_q;
        unique case (state_q)
            SEQ_PAUSE: begin
                if (dwell_q == '0) begin
                    state_d = SEQ_WAIT_GNT;
                end else begin
                    dwell_d = dwell_q - 1'b1;
                end
            end
            SEQ_WAIT_GNT: begin
                if (any_owed && gnt) begin
                    state_d = SEQ_CAS_LEAD;
                    dwell_d = SETUP_LD;
                end
            end
            SEQ_CAS_LEAD: begin
                if (dwell_q == '0) begin
                    state_d = SEQ_RAS_ACTIVE;
                    dwell_d = RAS_LD;
                end else begin
                    dwell_d = dwell_q - 1'b1;
                end
            end
            SEQ_RAS_ACTIVE: begin
                if (dwell_q == '0) begin
                    state_d = SEQ_PRECHARGE;
                    dwell_d = PRE_LD;
                end else begin
                    dwell_d = dwell_q - 1'b1;
                end
            end
            SEQ_PRECHARGE: begin
                if (dwell_q == '0) begin
                    state_d = SEQ_WAIT_GNT;
                end else begin
                    dwell_d = dwell_q - 1'b1;
                end
            end
            default: begin
                state_d = SEQ_PAUSE;
                dwell_d = PAUSE_LD;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_PAUSE;
            dwell_q <= PAUSE_LD;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            dwell_q <= dwell_d;
            if (state_q == SEQ_WAIT_GNT && !any_owed) begin
                ready_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cas_low   = (state_q == SEQ_CAS_LEAD) ||
                    ((state_q == SEQ_RAS_ACTIVE) && (dwell_q >= HOLD_TH));
        ras_n     = (state_q != SEQ_RAS_ACTIVE);
        ucas_n    = !cas_low;
        lcas_n    = !cas_low;
        we_n      = 1'b1;
        req       = (state_q != SEQ_PAUSE) && any_owed;
        load_init = (state_q == SEQ_PAUSE) && (dwell_q == '0);
        retire    = (state_q == SEQ_PRECHARGE) && (dwell_q == '0);
        ready     = ready_q;
    end

    // checker state: length of the current row-strobe low phase
    logic [DW-1:0] ras_low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_low_len <= '0;
        end else if (!ras_n) begin
            ras_low_len <= ras_low_len + 1'b1;
        end else begin
            ras_low_len <= '0;
        end
    end

    assert_cas_before_ras_R4 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!ucas_n && !lcas_n)
    );

    assert_ras_width_R5 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_low_len == DW'(RAS_LOW_CYC))
    );

    assert_strobes_granted_R8 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (!ras_n || !ucas_n || !lcas_n) |-> gnt
    );

    assert_req_release_R11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(state_q == SEQ_PRECHARGE)
    );

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ       = 200,
    parameter int PAUSE_US      = 200,
    parameter int RETENTION_US  = 8000,
    parameter int ROWS          = 512,
    parameter int T_RAS_NS      = 60,
    parameter int T_RP_NS       = 40,
    parameter int T_RC_NS       = 110,
    parameter int CAS_SETUP_CYC = 1,
    parameter int CAS_HOLD_CYC  = 2,
    parameter int INIT_BURST    = 8,
    parameter int MAX_OWED      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic ucas_n,
    output logic lcas_n,
    output logic we_n,
    output logic init_done
);
    localparam int PAUSE_CYC    = PAUSE_US * CLK_MHZ;
    localparam int INTERVAL_CYC = (RETENTION_US * CLK_MHZ) / ROWS;
    localparam int RAS_MIN_CYC  = ceil_div(T_RAS_NS * CLK_MHZ, 1000);
    localparam int RAS_LOW_CYC  = max2(RAS_MIN_CYC, CAS_HOLD_CYC + 1);
    localparam int RP_CYC       = ceil_div(T_RP_NS * CLK_MHZ, 1000);
    localparam int RC_CYC       = ceil_div(T_RC_NS * CLK_MHZ, 1000);
    localparam int PRE_CYC      = max2(RP_CYC, RC_CYC - RAS_LOW_CYC);

    logic tick;
    logic any_owed;
    logic load_init;
    logic retire;

    rfsh_interval_timer #(
        .PERIOD_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    rfsh_owed_counter #(
        .MAX_OWED  (MAX_OWED),
        .INIT_LOAD (INIT_BURST)
    ) u_owed (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (load_init),
        .inc       (tick),
        .dec       (retire),
        .any_owed  (any_owed)
    );

    rfsh_cycle_fsm #(
        .PAUSE_CYC     (PAUSE_CYC),
        .CAS_SETUP_CYC (CAS_SETUP_CYC),
        .CAS_HOLD_CYC  (CAS_HOLD_CYC),
        .RAS_LOW_CYC   (RAS_LOW_CYC),
        .PRE_CYC       (PRE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (ref_gnt),
        .any_owed  (any_owed),
        .load_init (load_init),
        .retire    (retire),
        .req       (ref_req),
        .ras_n     (ras_n),
        .ucas_n    (ucas_n),
        .lcas_n    (lcas_n),
        .we_n      (we_n),
        .ready     (init_done)
    );

    assert_no_tick_before_ready_R9 : assert property (
        @(posedge clk) disable iff (!rst_n) !init_done |-> !tick
    );

    assert_ready_after_burst_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) $rose(init_done) |-> !any_owed
    );

    assert_ready_sticky_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) init_done |=> init_done
    );

endmodule

// File: tb/dram_refresh_sequencer_test.sv
module dram_refresh_sequencer_test;
    localparam int CLK_MHZ      = 200;
    localparam int PAUSE_US     = 2;
    localparam int RETENTION_US = 1024;
    localparam int ROWS         = 512;
    localparam int SETUP        = 1;
    localparam int HOLD         = 2;
    localparam int INIT_N       = 8;
    localparam int CEIL_N       = 8;

    function automatic int ns2cyc(input int ns);
        return (ns * CLK_MHZ + 999) / 1000;
    endfunction

    localparam int E_PAUSE = PAUSE_US * CLK_MHZ;
    localparam int E_INT   = RETENTION_US * CLK_MHZ / ROWS;

    int e_ras, e_pre, e_rc;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic block = 1'b1;
    logic req, ras_n, ucas_n, lcas_n, we_n, init_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sequencer #(
        .CLK_MHZ      (CLK_MHZ),
        .PAUSE_US     (PAUSE_US),
        .RETENTION_US (RETENTION_US),
        .ROWS         (ROWS)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_gnt   (gnt),
        .ref_req   (req),
        .ras_n     (ras_n),
        .ucas_n    (ucas_n),
        .lcas_n    (lcas_n),
        .we_n      (we_n),
        .init_done (init_done)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // access-controller model: random grant latency, held while requested
    initial begin
        int wait_left;
        wait_left = -1;
        forever begin
            @(negedge clk);
            #2;
            if (!req) begin
                gnt = 1'b0;
                wait_left = -1;
            end else if (!gnt && !block) begin
                if (wait_left < 0) wait_left = $urandom_range(0, 6);
                if (wait_left == 0) gnt = 1'b1;
                else wait_left--;
            end
        end
    end

    // pin monitor
    int  fall_count = 0;
    int  req_rises = 0;
    int  last_req_rise = 0;
    int  t_init = 0;
    initial begin
        bit prev_ras, prev_cas, prev_req, prev_init, seen_rise;
        int cas_run, low_run, high_run, last_fall;
        bit cas_lo;
        prev_ras = 1; prev_cas = 0; prev_req = 0; prev_init = 0; seen_rise = 0;
        cas_run = 0; low_run = 0; high_run = 0; last_fall = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                cas_lo = !ucas_n && !lcas_n;
                check(we_n == 1'b1, "R7 write strobe high", we_n, 1);
                check(ucas_n == lcas_n, "R4 byte strobes equal", ucas_n, lcas_n);
                check(!((!ras_n || !ucas_n || !lcas_n) && !gnt), "R8 strobe without grant", gnt, 1);
                if (!ras_n && prev_ras) begin
                    check(cas_run == SETUP, "R4 CAS lead before RAS fall", cas_run, SETUP);
                    if (seen_rise) begin
                        check(high_run >= e_pre, "R6 precharge minimum", high_run, e_pre);
                        check(cyc - last_fall >= e_rc, "R6 cycle time minimum", cyc - last_fall, e_rc);
                    end
                    last_fall = cyc;
                    fall_count++;
                end
                if (ras_n && !prev_ras) begin
                    check(low_run == e_ras, "R5 RAS low width", low_run, e_ras);
                    seen_rise = 1;
                end
                if (!cas_lo && prev_cas) begin
                    check(cas_run == SETUP + HOLD, "R4 CAS low length", cas_run, SETUP + HOLD);
                    check(ras_n == 1'b0, "R4 CAS rises while RAS low", ras_n, 0);
                end
                if (!req && prev_req) begin
                    check(ras_n && high_run >= e_pre, "R11 request drop after precharge", high_run, e_pre);
                end
                if (req && !prev_req && init_done) begin
                    req_rises++;
                    last_req_rise = cyc;
                end
                if (init_done && !prev_init) begin
                    t_init = cyc;
                    check(fall_count == INIT_N, "R3 initial burst length", fall_count, INIT_N);
                end
                if (!init_done && prev_init) begin
                    check(1'b0, "R3 init_done dropped", 0, 1);
                end
                cas_run  = cas_lo ? cas_run + 1 : 0;
                low_run  = !ras_n ? low_run + 1 : 0;
                high_run = ras_n ? high_run + 1 : 0;
                prev_ras = ras_n; prev_cas = cas_lo; prev_req = req; prev_init = init_done;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) step();
    endtask

    task automatic replay(input int blk_at, input int rel_at, input int exp_n, input string tag);
        int f0;
        wait_until(blk_at);
        block = 1'b1;
        wait_until(rel_at);
        check(req == 1'b1, {tag, " request held while blocked"}, req, 1);
        check(ras_n && ucas_n && lcas_n, {tag, " strobes idle without grant"}, ras_n, 1);
        f0 = fall_count;
        block = 1'b0;
        step();
        while (req) step();
        check(fall_count - f0 == exp_n, {tag, " replayed refresh count"}, fall_count - f0, exp_n);
    endtask

    initial begin
        int f_after;
        void'($urandom(32'h2F61));
        e_ras = ns2cyc(60);
        e_pre = ns2cyc(40);
        e_rc  = ns2cyc(110);

        repeat (4) step();
        check(ras_n && ucas_n && lcas_n && we_n, "R1 strobes idle in reset", ras_n, 1);
        check(!req && !init_done, "R1 req/init low in reset", req, 0);
        rst_n = 1'b1;
        step();
        check(ras_n && ucas_n && lcas_n && we_n, "R1 strobes idle after reset", ras_n, 1);
        check(!req && !init_done, "R1 req/init low after reset", init_done, 0);

        // R2: exact pause length (cycle 0 was the release sample above)
        repeat (E_PAUSE - 2) step();
        check(req == 1'b0, "R2 no request before pause end", req, 0);
        check(ras_n && ucas_n, "R2 strobes idle during pause", ras_n, 1);
        step();
        check(req == 1'b1, "R2 request at pause end", req, 1);
        check(init_done == 1'b0, "R3 init_done low before burst", init_done, 0);
        block = 1'b0;

        while (!init_done) step();
        check(fall_count == INIT_N, "R3 refreshes at init_done", fall_count, INIT_N);

        // R9: periodic request spacing with prompt grants
        for (int k = 1; k <= 3; k++) begin
            while (req_rises < k) step();
            check(last_req_rise - t_init == k * E_INT, "R9 request period", last_req_rise - t_init, k * E_INT);
            check(fall_count == INIT_N + k - 1, "R9 one refresh per period", fall_count, INIT_N + k - 1);
        end

        // R10: withheld grant, below and above the ceiling
        replay(t_init + 3 * E_INT + 100, t_init + 6 * E_INT + 5, 3, "R10 short hold-off");
        replay(t_init + 7 * E_INT + 100, t_init + 19 * E_INT + 5, CEIL_N, "R10 saturated hold-off");

        f_after = fall_count;
        wait_until(t_init + 20 * E_INT + 60);
        check(fall_count == f_after + 1, "R9 periodic refresh resumes", fall_count, f_after + 1);
        check(init_done == 1'b1, "R3 init_done stays high", init_done, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule